// File: doc/BRIEF.md
# Error-Tagging Serial Receiver

This block receives asynchronous serial characters on one input line. It oversamples the line sixteen times per bit and qualifies each start bit at the middle of the bit. It then assembles 5 to 9 data bits, least significant first, checks an optional parity bit and the first stop bit, and places each character into a two-deep receive queue. Every queued character carries its own parity-error and framing-error marks in a 16-bit receive word. A line held low for a whole frame therefore appears as a framing-error word with zero data.

Software drives the block through a small word-addressed register port. The registers are:

- a command register that turns reception on and off;
- a status register with a data-valid bit;
- the receive word, where a read removes one entry;
- a sticky event flag register, with separate set, clear and enable registers that act by bit mask.

One interrupt line is the OR of each enabled flag.

Register map (bus_addr_i): 0 command (write), 1 status (read), 2 receive word (read, pops), 3 flags (read), 4 flag set (write), 5 flag clear (write), 6 flag enable (read/write). The oversampling tick is the clock divided by TICK_DIV.

Top module: `errtag_uart_rx`

## Requirements
- R1: After reset the receiver is disabled, status, flags and enables read 0, and irq_o is low.
- R2: A falling edge starts a character only if the line is still low 8 ticks later, at mid start bit. A low pulse shorter than that produces no entry.
- R3: Data bits are sampled at mid-bit, LSB first. cfg_nbits_i selects 5 to 9 bits. The receive word holds the data right-aligned in bits 8:0, zero above the character width, and bits 13:9 always read 0.
- R4: cfg_parity_i selects the parity mode: 0x means none, 10 means even, 11 means odd. Bit 14 of the word is set when the received parity bit mismatches, and it is always 0 with no parity.
- R5: Only the first stop bit is sampled. Bit 15 of the word is set when it is low, and a new start bit may follow directly after one stop bit.
- R6: A line held low through a whole frame gives exactly one word with data 0 and bit 15 set. No further character starts until the line has been seen high.
- R7: The queue holds two words in arrival order. Status bit 7 is 1 while the queue is non-empty. Reading address 2 returns the oldest word and removes it, and a read of an empty queue returns 0.
- R8: A character completing while two words are queued is discarded, the queued words are kept, and flag bit 4 is set.
- R9: The flag register has bit 2 (character received) and bit 4 (overflow), both sticky. Writing a mask to address 4 sets flags and writing a mask to address 5 clears them. Other bits read 0.
- R10: irq_o is high exactly when some flag bit and the same enable bit (address 6) are both 1.
- R11: A command write with bit 0 set enables reception and one with bit 1 set disables it, with disable winning. Status bit 0 shows the enable. While disabled the line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| cfg_nbits_i | input | 4 | Data bits per character, 5 to 9 |
| cfg_parity_i | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 5 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The receive path is swept over every width from 5 to 9 bits and all three parity modes. The data values include all-zeros, all-ones and scattered patterns, which separates bit order, alignment and parity sense. A full 256-value sweep at 8 bits with odd parity exposes any single stuck or swapped data position. Deliberately flipped parity bits and low stop bits show that each error mark is raised alone and in the right bit. A whole-frame low, a short glitch, back-to-back characters and three characters sent without reading separately test the break, start-qualification, single-stop and overflow-discard rules.

// File: rtl/errtag_uart_rx.sv
module errtag_uart_rx #(
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd_i,
  input  logic [3:0]  cfg_nbits_i,
  input  logic [1:0]  cfg_parity_i,
  input  logic        bus_wr_i,
  input  logic        bus_rd_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [4:0]  bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        irq_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [4:0] FLG_MASK = 5'b10100;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0]    sync;
  logic [PW-1:0] pre;
  st_t           st;
  logic [3:0]    cnt, bitn;
  logic [8:0]    sh;
  logic          pacc, armed, rx_en;
  logic [15:0]   ent0, ent1;
  logic [1:0]    fill;
  logic [4:0]    flg_q, ien_q;

  wire line = sync[1];
  wire tick = (pre == PW'(TICK_DIV - 1));

  wire wr_cmd = bus_wr_i && bus_addr_i == 3'd0;
  wire wr_set = bus_wr_i && bus_addr_i == 3'd4;
  wire wr_clr = bus_wr_i && bus_addr_i == 3'd5;
  wire wr_ien = bus_wr_i && bus_addr_i == 3'd6;
  wire pop    = bus_rd_i && bus_addr_i == 3'd2 && fill != 2'd0;

  wire        done  = rx_en && tick && st == S_STOP && cnt == 4'd15;
  wire [8:0]  data9 = sh >> (4'd9 - cfg_nbits_i);
  wire        perr  = cfg_parity_i[1] & (pacc ^ cfg_parity_i[0]);
  wire [15:0] word  = {~line, perr, 5'b0, data9};

  wire [1:0] fill_pp = fill - {1'b0, pop};
  wire       acc     = done && fill_pp != 2'd2;
  wire       ovf     = done && fill_pp == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      pre  <= '0;
    end else begin
      sync <= {sync[0], rxd_i};
      pre  <= tick ? '0 : pre + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
    end else if (wr_cmd) begin
      if (bus_wdata_i[1])      rx_en <= 1'b0;
      else if (bus_wdata_i[0]) rx_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; pacc <= 1'b0; armed <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE; cnt <= '0; armed <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          armed <= line;
          cnt   <= '0;
          if (armed && !line) st <= S_START;
        end
        S_START: begin
          if (cnt == 4'd7) begin
            cnt  <= '0;
            bitn <= '0;
            pacc <= 1'b0;
            st   <= line ? S_IDLE : S_DATA;
          end else cnt <= cnt + 4'd1;
        end
        S_DATA: begin
          if (cnt == 4'd15) begin
            cnt  <= '0;
            sh   <= {line, sh[8:1]};
            pacc <= pacc ^ line;
            bitn <= bitn + 4'd1;
            if (bitn == cfg_nbits_i - 4'd1) st <= cfg_parity_i[1] ? S_PAR : S_STOP;
          end else cnt <= cnt + 4'd1;
        end
        S_PAR: begin
          if (cnt == 4'd15) begin
            cnt  <= '0;
            pacc <= pacc ^ line;
            st   <= S_STOP;
          end else cnt <= cnt + 4'd1;
        end
        default: begin
          if (cnt == 4'd15) begin
            cnt   <= '0;
            armed <= 1'b0;
            st    <= S_IDLE;
          end else cnt <= cnt + 4'd1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0 <= '0; ent1 <= '0; fill <= '0;
    end else begin
      if (pop) ent0 <= ent1;
      if (acc) begin
        if (fill_pp == 2'd0) ent0 <= word;
        else                 ent1 <= word;
      end
      fill <= fill_pp + {1'b0, acc};
    end
  end

  wire [4:0] hw_set = {ovf, 1'b0, acc, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0; ien_q <= '0;
    end else begin
      flg_q <= ((flg_q & ~(wr_clr ? bus_wdata_i : 5'b0))
               | (wr_set ? bus_wdata_i : 5'b0) | hw_set) & FLG_MASK;
      if (wr_ien) ien_q <= bus_wdata_i & FLG_MASK;
    end
  end

  assign irq_o = |(flg_q & ien_q);

  always_comb begin
    case (bus_addr_i)
      3'd1:    bus_rdata_o = {8'b0, fill != 2'd0, 6'b0, rx_en};
      3'd2:    bus_rdata_o = (fill != 2'd0) ? ent0 : 16'h0;
      3'd3:    bus_rdata_o = {11'b0, flg_q};
      3'd6:    bus_rdata_o = {11'b0, ien_q};
      default: bus_rdata_o = 16'h0;
    endcase
  end
endmodule

// File: rtl/errtag_uart_rx_chk.sv
module errtag_uart_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [2:0]  bus_addr_i,
  input logic [4:0]  bus_wdata_i,
  input logic [15:0] bus_rdata_o,
  input logic [1:0]  fill,
  input logic [2:0]  st,
  input logic [4:0]  flg_q,
  input logic        acc
);
  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill != 2'd3);

  // R7
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 3'd2 && fill == 2'd1 && !acc) |=> fill == 2'd0);

  // R8
  ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flg_q[4]) && !$past(bus_wr_i && bus_addr_i == 3'd4 && bus_wdata_i[4]))
      |-> $past(fill) == 2'd2);

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 3'd0 && bus_wdata_i[1]) |=> st == 3'd0);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 3'd2) |-> bus_rdata_o[13:9] == 5'b0);

  // R9
  flag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q & 5'b01011) == 5'b0);
endmodule

bind errtag_uart_rx errtag_uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .fill(fill), .st(st), .flg_q(flg_q), .acc(acc)
);

// File: tb/errtag_uart_rx_tb_top.sv
module errtag_uart_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 1;
  localparam int BIT = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [3:0] nbits = 4'd8;
  logic [1:0] pmode = 2'b00;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [4:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  errtag_uart_rx #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .cfg_nbits_i(nbits), .cfg_parity_i(pmode),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [4:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic drive(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  function automatic logic [8:0] mask_of(input int nb);
    return 9'((1 << nb) - 1);
  endfunction

  task automatic send_char(input logic [8:0] d, input int nb, input logic [1:0] pm,
                           input bit flip, input bit stopv);
    logic p;
    p = ^(d & mask_of(nb));
    if (pm[0]) p = ~p;
    drive(1'b0);
    for (int i = 0; i < nb; i++) drive(d[i]);
    if (pm[1]) drive(p ^ flip);
    drive(stopv);
    if (!stopv) drive(1'b1);
  endtask

  function automatic logic [15:0] exp_word(input logic [8:0] d, input int nb,
                                           input logic [1:0] pm, input bit flip, input bit stopv);
    return {~stopv, pm[1] & flip, 5'b0, d & mask_of(nb)};
  endfunction

  task automatic expect_word(input logic [15:0] e, input string req);
    logic [15:0] v;
    bus_read(3'd1, v);
    check(v[7] == 1'b1, "R7 status valid", v, 16'h81);
    bus_read(3'd2, v);
    check(v == e, req, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [8:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(3'd1, v); check(v == 16'h0, "R1 status", v, 0);
    bus_read(3'd3, v); check(v == 16'h0, "R1 flags", v, 0);
    bus_read(3'd6, v); check(v == 16'h0, "R1 enables", v, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R11 disabled receiver ignores line
    send_char(9'h55, 8, 2'b00, 0, 1);
    bus_read(3'd1, v); check(v == 16'h0, "R11 disabled ignores", v, 0);
    bus_write(3'd0, 5'b00011);
    bus_read(3'd1, v); check(v[0] == 1'b0, "R11 disable wins", v, 0);
    bus_write(3'd0, 5'b00001);
    bus_read(3'd1, v); check(v == 16'h1, "R11 enabled", v, 1);
    repeat (BIT) @(negedge clk);

    // R3 R4 R5 sweep of widths, parity modes and values
    for (int nb = 5; nb <= 9; nb++) begin
      for (int pmi = 0; pmi < 3; pmi++) begin
        logic [1:0] pm;
        pm = (pmi == 0) ? 2'b00 : (pmi == 1) ? 2'b10 : 2'b11;
        nbits = 4'(nb); pmode = pm;
        for (int i = 0; i < 10; i++) begin
          bit flip, stopv;
          d = (i == 0) ? 9'h0 : (i == 1) ? 9'h1ff : 9'((i * 53 + nb * 7) ^ 9'h0a5);
          flip  = (i == 8) && pm[1];
          stopv = (i != 9);
          send_char(d, nb, pm, flip, stopv);
          expect_word(exp_word(d, nb, pm, flip, stopv),
                      flip ? "R4 parity error" : (!stopv ? "R5 framing error" : "R3 data word"));
        end
      end
    end

    // R3 full sweep 8 bits odd parity
    nbits = 4'd8; pmode = 2'b11;
    for (int k = 0; k < 256; k++) begin
      send_char(9'(k), 8, 2'b11, 0, 1);
      bus_read(3'd2, v);
      check(v == exp_word(9'(k), 8, 2'b11, 0, 1), "R3 sweep", v, exp_word(9'(k), 8, 2'b11, 0, 1));
    end
    bus_read(3'd1, v); check(v[7] == 1'b0, "R7 empty after pops", v, 1);
    bus_read(3'd2, v); check(v == 16'h0, "R7 empty read zero", v, 0);

    // R2 glitch rejected
    nbits = 4'd8; pmode = 2'b00;
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    bus_read(3'd1, v); check(v[7] == 1'b0, "R2 glitch ignored", v, 0);

    // R6 break
    drive(1'b0); for (int i = 0; i < 11; i++) drive(1'b0);
    drive(1'b1); drive(1'b1);
    expect_word(16'h8000, "R6 break word");
    bus_read(3'd1, v); check(v[7] == 1'b0, "R6 single break entry", v, 0);

    // R5 back-to-back characters with one stop bit
    send_char(9'h3c, 8, 2'b00, 0, 1);
    send_char(9'hc3, 8, 2'b00, 0, 1);
    expect_word(16'h003c, "R5 first back-to-back");
    expect_word(16'h00c3, "R5 second back-to-back");

    // R9 R10 flag set/clear/enable
    bus_write(3'd5, 5'b11111);
    bus_read(3'd3, v); check(v == 16'h0, "R9 clear all", v, 0);
    bus_write(3'd6, 5'b00000);
    bus_write(3'd4, 5'b11111);
    bus_read(3'd3, v); check(v == 16'h14, "R9 set mask", v, 16'h14);
    check(irq == 1'b0, "R10 masked irq", irq, 0);
    bus_write(3'd6, 5'b00100);
    @(negedge clk); check(irq == 1'b1, "R10 enabled irq", irq, 1);
    bus_write(3'd5, 5'b00100);
    @(negedge clk); check(irq == 1'b0, "R10 irq after clear", irq, 0);
    bus_read(3'd3, v); check(v == 16'h10, "R9 partial clear", v, 16'h10);
    bus_write(3'd5, 5'b10000);

    // R8 overflow
    bus_write(3'd6, 5'b10000);
    send_char(9'h11, 8, 2'b00, 0, 1);
    send_char(9'h22, 8, 2'b00, 0, 1);
    @(negedge clk); check(irq == 1'b0, "R8 no overflow at two", irq, 0);
    send_char(9'h33, 8, 2'b00, 0, 1);
    @(negedge clk); check(irq == 1'b1, "R10 overflow irq", irq, 1);
    bus_read(3'd3, v); check(v == 16'h14, "R8 overflow flag", v, 16'h14);
    expect_word(16'h0011, "R8 oldest kept");
    expect_word(16'h0022, "R8 second kept");
    bus_read(3'd1, v); check(v[7] == 1'b0, "R8 third discarded", v, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule